// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Device

This block is one output cell of a small sum-of-products programmable logic device. An AND array outside the cell presents a vector of product terms. The cell ORs them, applies a programmable polarity and drives three things: a pin data value, a pin driver enable and a feedback bit that returns to the array.

A two-bit global mode code is shared by every cell of the device. Two per-cell bits refine that mode: an architecture bit and a polarity bit. Together they make the cell one of four kinds:

- a clocked registered output;
- a combinatorial I/O whose enable comes from a product term;
- an always-driven combinatorial output;
- a dedicated input.

The register clears to zero at power-up. A synchronous preload path can force any value into it, so a test can load states that the array would never produce. Registered cells drive the pin from the inverted register output. As a result, an enabled registered pin reads high after power-up whatever its polarity.

Top module: `pld_out_cell`

## Requirements
- R1: The global mode code `gmode` selects the cell family. 2'b01 is registered mode. 2'b11 is complex mode, where the cell is a combinatorial I/O whatever `cell_alt` is. 2'b10 is simple mode. 2'b00 behaves as simple mode.
- R2: On every combinatorial path the pin value equals the relevant term sum when `cell_pos`=1, and its inverse when `cell_pos`=0.
- R3: In simple mode with `cell_alt`=0 the driver is always enabled and the value uses the OR of all terms. With `cell_alt`=1 the driver is off and `fb` follows `pin_in`.
- R4: A combinatorial I/O cell (registered mode with `cell_alt`=1, or complex mode) ORs terms `pterm[NTERM-1:1]` only. Its driver enable equals `pterm[0]`, and `fb` follows `pin_in`.
- R5: A registered cell (registered mode, `cell_alt`=0) loads its register at each rising clock edge. It loads the inverted OR of all terms when `cell_pos`=1, and the plain OR when `cell_pos`=0. The pin shows the inverted register and `fb` shows the register. The new value appears one clock edge after the terms are presented.
- R6: A registered cell enables its driver exactly when the shared active-low enable `reg_oe_n` is 0. `reg_oe_n` has no effect on any other cell kind.
- R7: While `rst_n` is low the register is 0 without waiting for a clock, and an enabled registered pin reads 1 for both polarities.
- R8: `preload_en`=1 at a rising edge loads `preload_val` into the register, taking precedence over the term data, in every mode.
- R9: When the cell is not a registered cell and no preload is requested, the register keeps its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common register clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| gmode | input | 2 | Global mode code shared by all cells |
| cell_alt | input | 1 | Per-cell architecture bit |
| cell_pos | input | 1 | Per-cell polarity, 1 = active high |
| pterm | input | NTERM | Product terms from the AND array |
| reg_oe_n | input | 1 | Shared active-low enable for registered cells |
| preload_en | input | 1 | Synchronous test preload request |
| preload_val | input | 1 | Value to preload into the register |
| pin_in | input | 1 | Level seen on the pin |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback to the AND array |

## Verification
Every combinatorial result (pin value, enable and pin feedback) is due in the same cycle as its inputs. The bench therefore checks it 2 ns after each input change, before any clock edge can move the register. That early check also shows that a mode switch exposes the held register without an extra edge. Register-sourced results are due one rising edge after their terms, preload or reset. The bench advances its behavioural register model at that edge and compares again at the following falling edge, so both the pre-edge and post-edge views of every vector are compared.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

  typedef enum logic [1:0] {
    GM_LEGACY = 2'b00,
    GM_REG    = 2'b01,
    GM_SIMPLE = 2'b10,
    GM_CPLX   = 2'b11
  } gmode_e;

  typedef enum logic [1:0] {
    CK_REG = 2'd0,   // clocked output
    CK_IO  = 2'd1,   // combinatorial I/O, term-driven enable
    CK_OUT = 2'd2,   // always-driven combinatorial output
    CK_IN  = 2'd3    // dedicated input, driver off
  } cell_kind_e;

  // Map global mode plus per-cell architecture bit to a cell kind.
  function automatic cell_kind_e decode_kind(input gmode_e gm, input logic alt);
    cell_kind_e k;
    case (gm)
      GM_REG:  k = alt ? CK_IO : CK_REG;
      GM_CPLX: k = CK_IO;
      default: k = alt ? CK_IN : CK_OUT;
    endcase
    return k;
  endfunction

  // Programmable polarity: pos=1 passes the sum, pos=0 inverts it.
  function automatic logic apply_pol(input logic sum, input logic pos);
    return pos ? sum : ~sum;
  endfunction

  // Register input chosen so that the inverted register pin equals
  // the polarity-adjusted sum.
  function automatic logic reg_d(input logic sum, input logic pos);
    return ~apply_pol(sum, pos);
  endfunction

endpackage

// File: rtl/pld_term_sum.sv
module pld_term_sum #(
  parameter int NTERM = 8
) (
  input  logic [NTERM-1:0] pterm,
  output logic             sum_all,
  output logic             sum_rest,
  output logic             en_term
);
  localparam int EN_IDX = 0;

  logic [NTERM-1:0] chain_all;
  logic [NTERM-1:0] chain_rest;

  generate
    for (genvar g = 0; g < NTERM; g++) begin : g_or
      if (g == 0) begin : g_first
        assign chain_all[g]  = pterm[g];
        assign chain_rest[g] = 1'b0;
      end else begin : g_next
        assign chain_all[g]  = chain_all[g-1] | pterm[g];
        assign chain_rest[g] = chain_rest[g-1] | pterm[g];
      end
    end
  endgenerate

  assign sum_all  = chain_all[NTERM-1];
  assign sum_rest = chain_rest[NTERM-1];
  assign en_term  = pterm[EN_IDX];
endmodule

// File: rtl/pld_cell_reg.sv
module pld_cell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic load_val,
  input  logic cap_en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (load_en) q <= load_val;
    else if (cap_en)  q <= d;
  end
endmodule

// File: rtl/pld_cell_route.sv
module pld_cell_route
  import pld_cell_pkg::*;
(
  input  cell_kind_e kind,
  input  logic       pos,
  input  logic       sum_all,
  input  logic       sum_rest,
  input  logic       en_term,
  input  logic       q,
  input  logic       reg_oe_n,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb
);
  always_comb begin
    case (kind)
      CK_REG: begin
        pin_out = ~q;
        pin_oe  = ~reg_oe_n;
        fb      = q;
      end
      CK_IO: begin
        pin_out = apply_pol(sum_rest, pos);
        pin_oe  = en_term;
        fb      = pin_in;
      end
      CK_OUT: begin
        pin_out = apply_pol(sum_all, pos);
        pin_oe  = 1'b1;
        fb      = pin_in;
      end
      default: begin
        pin_out = apply_pol(sum_all, pos);
        pin_oe  = 1'b0;
        fb      = pin_in;
      end
    endcase
  end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int NTERM = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       gmode,
  input  logic             cell_alt,
  input  logic             cell_pos,
  input  logic [NTERM-1:0] pterm,
  input  logic             reg_oe_n,
  input  logic             preload_en,
  input  logic             preload_val,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb
);
  // Named internal events for the checker
  cell_kind_e kind;
  logic       is_reg_cell;
  logic       sum_all, sum_rest, en_term;
  logic       d_next;
  logic       q_now;

  assign kind        = decode_kind(gmode_e'(gmode), cell_alt);
  assign is_reg_cell = (kind == CK_REG);
  assign d_next      = reg_d(sum_all, cell_pos);

  pld_term_sum #(.NTERM(NTERM)) u_sum (
    .pterm    (pterm),
    .sum_all  (sum_all),
    .sum_rest (sum_rest),
    .en_term  (en_term)
  );

  pld_cell_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (preload_en),
    .load_val (preload_val),
    .cap_en   (is_reg_cell),
    .d        (d_next),
    .q        (q_now)
  );

  pld_cell_route u_route (
    .kind     (kind),
    .pos      (cell_pos),
    .sum_all  (sum_all),
    .sum_rest (sum_rest),
    .en_term  (en_term),
    .q        (q_now),
    .reg_oe_n (reg_oe_n),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .fb       (fb)
  );
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk
  import pld_cell_pkg::*;
#(
  parameter int NTERM = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NTERM-1:0] pterm,
  input logic             cell_pos,
  input logic             reg_oe_n,
  input logic             preload_en,
  input logic             preload_val,
  input logic             pin_in,
  input logic             pin_out,
  input logic             pin_oe,
  input logic             fb,
  input cell_kind_e       kind,
  input logic             q_now
);
  // R5: capture of the term sum, polarity folded into the stored value
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_REG && !preload_en) |=>
      (q_now == ($past(cell_pos) ? ~(|$past(pterm)) : (|$past(pterm)))));

  // R5: registered pin shows the inverted register, feedback the register
  a_r5_reg_view: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_REG) |-> (pin_out == ~q_now && fb == q_now));

  // R6: shared enable governs registered cells
  a_r6_shared_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_REG) |-> (pin_oe == !reg_oe_n));

  // R3: simple-mode driver states
  a_r3_out_on: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_OUT) |-> pin_oe);
  a_r3_in_off: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_IN) |-> (!pin_oe && fb == pin_in));

  // R4: I/O enable from the lowest term, feedback from the pin
  a_r4_io_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_IO) |-> (pin_oe == pterm[0] && fb == pin_in));

  // R8: preload wins at the edge
  a_r8_preload: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en |=> (q_now == $past(preload_val)));

  // R9: register holds outside registered cells
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != CK_REG && !preload_en) |=> (q_now == $past(q_now)));

  // R7: power-up reset clears the register, registered pin reads high
  a_r7_reset: assert property (@(posedge clk)
    !rst_n |-> (q_now == 1'b0 && (kind != CK_REG || pin_out)));
endmodule

bind pld_out_cell pld_out_cell_chk #(.NTERM(NTERM)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pterm       (pterm),
  .cell_pos    (cell_pos),
  .reg_oe_n    (reg_oe_n),
  .preload_en  (preload_en),
  .preload_val (preload_val),
  .pin_in      (pin_in),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .fb          (fb),
  .kind        (kind),
  .q_now       (q_now)
);

// File: tb/tb_pld_out_cell.sv
`timescale 1ns/1ps
module tb_pld_out_cell;
  localparam int NT = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    gmode;
  logic          cell_alt, cell_pos;
  logic [NT-1:0] pterm;
  logic          reg_oe_n, preload_en, preload_val, pin_in;
  logic          pin_out, pin_oe, fb;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R7";
  bit    model_q = 1'b0;   // behavioural register image

  always #10 clk = ~clk;   // 50 MHz

  pld_out_cell #(.NTERM(NT)) dut (
    .clk(clk), .rst_n(rst_n), .gmode(gmode), .cell_alt(cell_alt),
    .cell_pos(cell_pos), .pterm(pterm), .reg_oe_n(reg_oe_n),
    .preload_en(preload_en), .preload_val(preload_val), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  // 0 = clocked, 1 = I/O, 2 = always-on output, 3 = input
  function automatic int kind_of();
    if (gmode == 2'b01) return cell_alt ? 1 : 0;
    if (gmode == 2'b11) return 1;
    return cell_alt ? 3 : 2;
  endfunction

  task automatic check(string when);
    int  k = kind_of();
    bit  any_all = 1'b0;
    bit  any_hi  = 1'b0;
    bit  e_out, e_oe, e_fb;
    bit  q = rst_n ? model_q : 1'b0;
    for (int i = 0; i < NT; i++) begin
      if (pterm[i]) any_all = 1'b1;
      if (pterm[i] && i > 0) any_hi = 1'b1;
    end
    case (k)
      0: begin e_out = !q; e_oe = !reg_oe_n; e_fb = q; end
      1: begin e_out = cell_pos ? any_hi : !any_hi; e_oe = pterm[0]; e_fb = pin_in; end
      2: begin e_out = cell_pos ? any_all : !any_all; e_oe = 1'b1; e_fb = pin_in; end
      default: begin e_out = cell_pos ? any_all : !any_all; e_oe = 1'b0; e_fb = pin_in; end
    endcase
    vectors++;
    if (pin_out !== e_out || pin_oe !== e_oe || fb !== e_fb) begin
      miscompares++;
      $display("FAIL %s (%s) mode=%b alt=%b pos=%b terms=%h: out/oe/fb got %b%b%b exp %b%b%b",
               cur_req, when, gmode, cell_alt, cell_pos, pterm,
               pin_out, pin_oe, fb, e_out, e_oe, e_fb);
    end
  endtask

  // One clock: drive after a falling edge, check before and after the rising edge.
  task automatic cyc(input logic [1:0] gm, input bit alt, input bit pos,
                     input logic [NT-1:0] pt, input bit oen, input bit pre,
                     input bit pv, input bit pin);
    bit any_all;
    gmode = gm; cell_alt = alt; cell_pos = pos; pterm = pt;
    reg_oe_n = oen; preload_en = pre; preload_val = pv; pin_in = pin;
    #2 check("pre-edge");
    @(posedge clk);
    any_all = |pt;
    if (!rst_n)          model_q = 1'b0;
    else if (pre)        model_q = pv;
    else if (kind_of() == 0) model_q = pos ? !any_all : any_all;
    @(negedge clk);
    check("post-edge");
  endtask

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog expired during %s", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    gmode = 2'b01; cell_alt = 0; cell_pos = 0; pterm = '1;
    reg_oe_n = 0; preload_en = 0; preload_val = 0; pin_in = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    @(negedge clk);
    // R7: reset holds Q at 0, enabled registered pin high for both polarities
    cur_req = "R7";
    cyc(2'b01, 0, 0, 8'hFF, 0, 0, 0, 0);
    cyc(2'b01, 0, 1, 8'h00, 0, 0, 0, 0);
    cyc(2'b01, 0, 1, 8'h00, 0, 1, 1, 0);
    rst_n = 1'b1;

    // R8: preload overrides terms in a registered cell
    cur_req = "R8";
    cyc(2'b01, 0, 1, 8'hFF, 0, 1, 1, 0);
    cyc(2'b01, 0, 1, 8'h00, 0, 1, 0, 0);
    cyc(2'b10, 1, 0, 8'h5A, 0, 1, 1, 1);   // preload while a dedicated input
    cyc(2'b11, 1, 1, 8'h00, 0, 1, 0, 0);   // preload while complex I/O

    // R9: hold while not registered, then visible on switching back
    cur_req = "R9";
    cyc(2'b01, 0, 0, 8'h00, 0, 1, 1, 0);
    for (int i = 0; i < 4; i++) cyc(2'b11, 1, 0, 8'h00, 0, 0, 0, i[0]);
    cyc(2'b10, 0, 1, 8'h00, 0, 0, 0, 0);
    cyc(2'b01, 0, 0, 8'h00, 0, 0, 0, 0);

    // R5: clocked capture, both polarities, random terms
    cur_req = "R5";
    for (int i = 0; i < 200; i++)
      cyc(2'b01, 0, i[0], (i % 3 == 0) ? 8'h00 : 8'($urandom), 0, 0, 0, 1);

    // R6: shared enable on a registered cell, no effect elsewhere
    cur_req = "R6";
    for (int i = 0; i < 8; i++) cyc(2'b01, 0, 1, 8'($urandom), i[0], 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(2'b11, 1, 1, 8'($urandom), i[0], 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(2'b10, i[1], 0, 8'($urandom), i[0], 0, 0, 1);

    // R4 and R2: I/O cells sweep every term pattern and polarity
    cur_req = "R4";
    for (int v = 0; v < 256; v++) begin
      cyc(2'b01, 1, v[0], 8'(v), 0, 0, 0, v[1]);
      cyc(2'b11, 1, ~v[0], 8'(v), 1, 0, 0, v[2]);
    end
    cur_req = "R2";
    for (int v = 0; v < 256; v++) cyc(2'b11, v[3], v[0], 8'(v), 0, 0, 0, 0);

    // R3: simple mode output and input, every term pattern
    cur_req = "R3";
    for (int v = 0; v < 256; v++) begin
      cyc(2'b10, 0, v[0], 8'(v), 1, 0, 0, v[1]);
      cyc(2'b10, 1, v[1], 8'(v), 0, 0, 0, v[0]);
    end

    // R1: code 2'b00 behaves as simple mode; complex ignores alt
    cur_req = "R1";
    for (int v = 0; v < 64; v++) begin
      cyc(2'b00, v[0], v[1], 8'($urandom), 0, 0, 0, v[2]);
      cyc(2'b11, 0, v[1], 8'($urandom), 0, 0, 0, v[2]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule